// File: doc/BRIEF.md
# General-Purpose Pin Port with Per-Pin Interrupt Detection

This block is a port of general-purpose pins, configured and observed through a small memory-mapped register bus. Software picks the direction of each pin and sets the value driven on outputs. It can also read the live state of every pin. Every pin passes through a synchronizer before any logic sees it.

Each pin also has its own interrupt detector, set by three per-pin bits:
- A sense bit chooses edge or level detection.
- A dual-edge bit, when set, fires on both transitions and ignores polarity.
- A polarity bit picks rising/high or falling/low.

Edge events are held in a status latch until software writes a one to clear them. Level conditions are reported live. An enable mask gates both the per-pin interrupt outputs and one registered combined interrupt line.

The bus has no read strobe: read data is a combinational function of the address. A write takes effect on the clock edge on which the write enable is high.

Top module: `pio_port`

## Requirements
- R1: After reset, every register reads 0. `pin_oe_o`, `pin_o`, `irq_pin_o` and `irq_any_o` are all 0.
- R2: Bit n of the direction register (offset 0x20) set to 1 makes pin n an output, and `pin_oe_o[n]` follows it from the clock edge of the write. `pin_o` carries the data register (offset 0x00).
- R3: Reading offset 0x00 returns a per-pin mix. An output pin returns its driven value. An input pin returns its synchronized level, which changes on the second rising clock edge after the pin changes.
- R4: With sense bit n (offset 0x24) at 0, pin n is edge sensitive. Polarity bit n (offset 0x2C) set to 1 selects rising edges, and 0 selects falling edges. An edge of the other direction is ignored.
- R5: A selected edge shows in raw status (offset 0x14) from the third rising clock edge after the pin changes. It stays set after the pin returns to its old level.
- R6: Dual-edge bit n (offset 0x28) set to 1 makes both rising and falling edges on pin n set its status bit, whatever the polarity bit holds.
- R7: With sense bit n at 1, raw status bit n follows the pin live: high when the pin is high with polarity 1, or low with polarity 0. It tracks the pin two clock edges after each change.
- R8: Writing to offset 0x1C clears the latched edge status bits where the data is 1. Bits where the data is 0 are unaffected, and writes there have no effect on level-sensitive bits.
- R9: Enable bit n (offset 0x10) gates pin n. `irq_pin_o` equals raw status AND enable. The masked status register (offset 0x18) reads the same value.
- R10: `irq_any_o` equals the OR of all masked status bits as they were one clock edge earlier.
- R11: An unmapped offset reads as 0, and writes to it change nothing. Writes to offsets 0x14 and 0x18 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 6 | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| pin_i | input | N_PINS | Pin levels from the pads |
| pin_o | output | N_PINS | Values to drive on output pins |
| pin_oe_o | output | N_PINS | Output enable per pin |
| irq_pin_o | output | N_PINS | Per-pin masked interrupt |
| irq_any_o | output | 1 | Registered combined interrupt |

## Verification
The bench builds the block with its defaults: 32 pins and a two-stage synchronizer. This makes every word written and read exactly one bit per pin, so each expected value can be compared as a full 32-bit word. The short synchronizer lets the bench check the exact edge on which data reads, level status, latched edges and the combined line change. Different pins are given different sense, dual-edge and polarity settings in turn, so each mode is tested in isolation while the raw status of the other pins is also checked.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned REG_AW = 6;
  localparam int unsigned BUS_DW = 32;

  localparam logic [REG_AW-1:0] OFS_DATA  = 6'h00;
  localparam logic [REG_AW-1:0] OFS_IE    = 6'h10;
  localparam logic [REG_AW-1:0] OFS_RAW   = 6'h14;
  localparam logic [REG_AW-1:0] OFS_MSK   = 6'h18;
  localparam logic [REG_AW-1:0] OFS_CLR   = 6'h1C;
  localparam logic [REG_AW-1:0] OFS_DIR   = 6'h20;
  localparam logic [REG_AW-1:0] OFS_SENSE = 6'h24;
  localparam logic [REG_AW-1:0] OFS_DUAL  = 6'h28;
  localparam logic [REG_AW-1:0] OFS_POL   = 6'h2C;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pio_irq_detect.sv
module pio_irq_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_s_i,
  input  logic [W-1:0] sense_i,
  input  logic [W-1:0] dual_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] hit_o,
  output logic [W-1:0] lat_o,
  output logic [W-1:0] raw_o
);
  logic [W-1:0] prev_q, lat_q;
  logic [W-1:0] rise, fall, edge_sel, lvl;

  always_comb begin
    rise     = pin_s_i & ~prev_q;
    fall     = ~pin_s_i & prev_q;
    edge_sel = (dual_i & (rise | fall)) | (~dual_i & ((pol_i & rise) | (~pol_i & fall)));
    hit_o    = ~sense_i & edge_sel;
    lvl      = ~(pin_s_i ^ pol_i);
    raw_o    = (sense_i & lvl) | (~sense_i & lat_q);
  end

  // a new edge in the same cycle as a clear wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      lat_q  <= '0;
    end else begin
      prev_q <= pin_s_i;
      lat_q  <= (lat_q & ~clr_i) | hit_o;
    end
  end

  assign lat_o = lat_q;
endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [BUS_DW-1:0] wdata_i,
  input  logic [W-1:0]      pin_s_i,
  input  logic [W-1:0]      raw_i,
  output logic [W-1:0]      out_o,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      ie_o,
  output logic [W-1:0]      sense_o,
  output logic [W-1:0]      dual_o,
  output logic [W-1:0]      pol_o,
  output logic [W-1:0]      clr_o,
  output logic [BUS_DW-1:0] rdata_o
);
  logic [W-1:0] wd, rsel;

  assign wd    = wdata_i[W-1:0];
  assign clr_o = (wr_en_i && addr_i == OFS_CLR) ? wd : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_o   <= '0;
      dir_o   <= '0;
      ie_o    <= '0;
      sense_o <= '0;
      dual_o  <= '0;
      pol_o   <= '0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        OFS_DATA:  out_o   <= wd;
        OFS_DIR:   dir_o   <= wd;
        OFS_IE:    ie_o    <= wd;
        OFS_SENSE: sense_o <= wd;
        OFS_DUAL:  dual_o  <= wd;
        OFS_POL:   pol_o   <= wd;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr_i)
      OFS_DATA:  rsel = (dir_o & out_o) | (~dir_o & pin_s_i);
      OFS_IE:    rsel = ie_o;
      OFS_RAW:   rsel = raw_i;
      OFS_MSK:   rsel = raw_i & ie_o;
      OFS_DIR:   rsel = dir_o;
      OFS_SENSE: rsel = sense_o;
      OFS_DUAL:  rsel = dual_o;
      OFS_POL:   rsel = pol_o;
      default:   rsel = '0;
    endcase
    rdata_o = BUS_DW'(rsel);
  end
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int unsigned N_PINS      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [5:0]        addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pin_o,
  output logic [N_PINS-1:0] pin_oe_o,
  output logic [N_PINS-1:0] irq_pin_o,
  output logic              irq_any_o
);
  logic [N_PINS-1:0] pin_s, raw, edge_hit, edge_lat;
  logic [N_PINS-1:0] out_q, dir_q, ie_q, sense_q, dual_q, pol_q, clr;

  pio_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pin_s)
  );

  pio_irq_detect #(.W(N_PINS)) u_det (
    .clk_i, .rst_ni,
    .pin_s_i(pin_s), .sense_i(sense_q), .dual_i(dual_q), .pol_i(pol_q),
    .clr_i(clr), .hit_o(edge_hit), .lat_o(edge_lat), .raw_o(raw)
  );

  pio_regs #(.W(N_PINS)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wdata_i,
    .pin_s_i(pin_s), .raw_i(raw),
    .out_o(out_q), .dir_o(dir_q), .ie_o(ie_q), .sense_o(sense_q),
    .dual_o(dual_q), .pol_o(pol_q), .clr_o(clr), .rdata_o
  );

  assign pin_o     = out_q;
  assign pin_oe_o  = dir_q;
  assign irq_pin_o = raw & ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_any_o <= 1'b0;
    else         irq_any_o <= |irq_pin_o;
  end
endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk #(
  parameter int unsigned N = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [5:0]   addr_i,
  input logic         wr_en_i,
  input logic [31:0]  wdata_i,
  input logic [31:0]  rdata_o,
  input logic [N-1:0] pin_oe_o,
  input logic [N-1:0] irq_pin_o,
  input logic         irq_any_o,
  input logic [N-1:0] edge_hit,
  input logic [N-1:0] edge_lat
);
  logic mapped, wr_dir, wr_ie, wr_clr;

  always_comb begin
    mapped = addr_i inside {6'h00, 6'h10, 6'h14, 6'h18, 6'h20, 6'h24, 6'h28, 6'h2C};
    wr_dir = wr_en_i && addr_i == 6'h20;
    wr_ie  = wr_en_i && addr_i == 6'h10;
    wr_clr = wr_en_i && addr_i == 6'h1C;
  end

  AST_OE_TRACKS_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dir |=> pin_oe_o == $past(wdata_i[N-1:0])); // R2

  AST_LATCH_NEEDS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_lat & ~$past(edge_lat) & ~$past(edge_hit)) == '0); // R5

  AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> (edge_lat & $past(wdata_i[N-1:0] & ~edge_hit)) == '0); // R8

  AST_ENABLE_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ie |=> (irq_pin_o & ~$past(wdata_i[N-1:0])) == '0); // R9

  AST_ANY_REGISTERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_any_o == $past(|irq_pin_o)); // R10

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |-> rdata_o == '0); // R11
endmodule

bind pio_port pio_port_chk #(.N(N_PINS)) u_chk (
  .clk_i, .rst_ni, .addr_i, .wr_en_i, .wdata_i, .rdata_o,
  .pin_oe_o, .irq_pin_o, .irq_any_o, .edge_hit, .edge_lat
);

// File: tb/pio_port_tb.sv
module pio_port_tb;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out, pin_oe, irq_pin;
  logic        irq_any;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pio_port #(.N_PINS(N), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe),
    .irq_pin_o(irq_pin), .irq_any_o(irq_any)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    addr  = a;
    wdata = d;
    we    = 1'b1;
    cyc();
    we    = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic config_pins(input logic [31:0] sense, dual, pol, ie);
    wr(6'h24, sense);
    wr(6'h28, dual);
    wr(6'h2C, pol);
    wr(6'h10, ie);
  endtask

  task automatic quiesce();
    pin_in = '0;
    cyc(4);
    wr(6'h1C, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    foreach (u_offs[i]) rd_chk($sformatf("R1 reg %h", u_offs[i]), u_offs[i], 32'h0);
    chk("R1 pin_oe", pin_oe, '0);
    chk("R1 pin_o", pin_out, '0);
    chk("R1 irq_pin", irq_pin, '0);
    chk("R1 irq_any", {31'h0, irq_any}, 32'h0);
  endtask

  logic [5:0] u_offs [9] = '{6'h00, 6'h10, 6'h14, 6'h18, 6'h20, 6'h24, 6'h28, 6'h2C, 6'h1C};

  task automatic t_output();
    wr(6'h20, 32'h0000_FFFF);
    wr(6'h00, 32'hA5A5_5A5A);
    chk("R2 pin_oe", pin_oe, 32'h0000_FFFF);
    chk("R2 pin_o", pin_out, 32'hA5A5_5A5A);
    pin_in = 32'h1234_5678;
    cyc();
    rd_chk("R3 data one edge", 6'h00, 32'h0000_5A5A);
    cyc();
    rd_chk("R3 data two edges", 6'h00, 32'h1234_5A5A);
    wr(6'h20, 32'h0);
    rd_chk("R3 all inputs", 6'h00, 32'h1234_5678);
    chk("R2 oe cleared", pin_oe, '0);
  endtask

  task automatic t_rise();
    config_pins(32'h0, 32'h0, 32'h1, 32'h1);
    quiesce();
    pin_in[0] = 1'b1;
    cyc(2);
    rd_chk("R5 raw before third edge", 6'h14, 32'h0);
    cyc();
    rd_chk("R5 raw at third edge", 6'h14, 32'h1);
    rd_chk("R9 masked", 6'h18, 32'h1);
    chk("R10 any not yet", {31'h0, irq_any}, 32'h0);
    cyc();
    chk("R10 any set", {31'h0, irq_any}, 32'h1);
    pin_in[0] = 1'b0;
    cyc(4);
    rd_chk("R5 latched after return", 6'h14, 32'h1);
    wr(6'h1C, 32'hFFFF_FFFE);
    rd_chk("R8 zero bit no effect", 6'h14, 32'h1);
    wr(6'h1C, 32'h1);
    rd_chk("R8 cleared", 6'h14, 32'h0);
    cyc();
    chk("R10 any dropped", {31'h0, irq_any}, 32'h0);
  endtask

  task automatic t_fall();
    config_pins(32'h0, 32'h0, 32'h0, 32'h2);
    quiesce();
    pin_in[1] = 1'b1;
    cyc(4);
    rd_chk("R4 rising ignored", 6'h14, 32'h0);
    pin_in[1] = 1'b0;
    cyc(4);
    rd_chk("R4 falling caught", 6'h14, 32'h2);
    chk("R9 irq_pin fall", irq_pin, 32'h2);
  endtask

  task automatic t_dual();
    config_pins(32'h0, 32'h4, 32'h0, 32'h4);
    quiesce();
    pin_in[2] = 1'b1;
    cyc(4);
    rd_chk("R6 rise with pol 0", 6'h14, 32'h4);
    wr(6'h1C, 32'h4);
    rd_chk("R6 cleared", 6'h14, 32'h0);
    pin_in[2] = 1'b0;
    cyc(4);
    rd_chk("R6 fall", 6'h14, 32'h4);
  endtask

  task automatic t_level();
    config_pins(32'h18, 32'h0, 32'h08, 32'h18);
    quiesce();
    rd_chk("R7 low level active", 6'h14, 32'h10);
    pin_in[3] = 1'b1;
    cyc();
    rd_chk("R7 one edge", 6'h14, 32'h10);
    cyc();
    rd_chk("R7 high level", 6'h14, 32'h18);
    chk("R9 irq_pin level", irq_pin, 32'h18);
    wr(6'h1C, 32'h18);
    rd_chk("R8 level not cleared", 6'h14, 32'h18);
    pin_in[3] = 1'b0;
    pin_in[4] = 1'b1;
    cyc(2);
    rd_chk("R7 both inactive", 6'h14, 32'h0);
  endtask

  task automatic t_mask();
    config_pins(32'h0, 32'h0, 32'h20, 32'h0);
    quiesce();
    pin_in[5] = 1'b1;
    cyc(4);
    rd_chk("R9 raw without enable", 6'h14, 32'h20);
    rd_chk("R9 masked zero", 6'h18, 32'h0);
    chk("R9 irq_pin zero", irq_pin, 32'h0);
    chk("R10 any zero", {31'h0, irq_any}, 32'h0);
    wr(6'h10, 32'h20);
    rd_chk("R9 masked on", 6'h18, 32'h20);
    chk("R9 irq_pin on", irq_pin, 32'h20);
    cyc();
    chk("R10 any on", {31'h0, irq_any}, 32'h1);
  endtask

  task automatic t_unmapped();
    wr(6'h04, 32'hFFFF_FFFF);
    wr(6'h30, 32'hFFFF_FFFF);
    wr(6'h3C, 32'hFFFF_FFFF);
    wr(6'h14, 32'h0);
    wr(6'h18, 32'h0);
    rd_chk("R11 read 0x04", 6'h04, 32'h0);
    rd_chk("R11 read 0x30", 6'h30, 32'h0);
    rd_chk("R11 read 0x3C", 6'h3C, 32'h0);
    rd_chk("R11 raw kept", 6'h14, 32'h20);
    rd_chk("R11 ie kept", 6'h10, 32'h20);
    rd_chk("R11 pol kept", 6'h2C, 32'h20);
    rd_chk("R11 sense kept", 6'h24, 32'h0);
    rd_chk("R11 dir kept", 6'h20, 32'h0);
    rd_chk("R11 data kept", 6'h00, 32'h20);
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(2);
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_output();
    t_rise();
    t_fall();
    t_dual();
    t_level();
    t_mask();
    t_unmapped();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule